// File: doc/BRIEF.md
# Byte-Wide Flash Command Controller

This block is a clock-synchronous model of the control logic in a byte-wide, non-volatile parallel memory. A host drives it with active-low chip-enable, output-enable and write-enable strobes, a 16-bit address and an 8-bit data bus. Reads behave like a plain read-only memory. Writes do not change storage directly. Instead, a short sequence of keyed bus cycles selects one of three commands: program one byte, erase the whole array, or set a lock that shields the bottom of the array from erase.

Program and erase take a fixed number of clock cycles, counted inside the block. During that time the read path returns a polling status in place of array data, and new bus writes are dropped. The storage is a scaled register array with 2^MEM_AW bytes, indexed by the low address bits. The protected boot region is its lowest BOOT_BYTES bytes. The pad driver is modelled as a data output plus an output-enable flag.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: `dout_en` is 1 and `dout` carries the byte at the low MEM_AW address bits only when `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other combination `dout_en` is 0 and `dout` is 8'h00.
- R2: A program stores old AND new, so a program can clear bits but never set them. Programming a 0 bit with a 1 leaves it 0.
- R3: The program command is four write cycles: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the target address and data.
- R4: The chip erase command is six write cycles: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h. When the erase ends, every unprotected byte reads FFh.
- R5: A write cycle is framed by the strobe (ce_n OR we_n). The address is taken on its falling edge and the data on its rising edge, whichever of the two pins causes that edge.
- R6: Any write cycle that does not match the next expected address/data pair returns the sequencer to idle, and nothing is written.
- R7: A program is busy for PROG_CYC clock cycles after the clock edge that accepts its final cycle, and an erase for ERASE_CYC cycles. The array update takes effect at the end of that window.
- R8: While busy, a read returns {~d7, 7'b0}, where d7 is bit 7 of the byte being programmed, or 8'h00 during an erase. Write cycles issued while busy have no effect.
- R9: The boot lock is set either by the sequence AAh, 55h, 80h, AAh, 55h, 40h (at the same addresses as R4) or by a high `boot_lock_in` on any clock edge. Once set, it stays set until reset. When it is set, erase leaves bytes 0 to BOOT_BYTES-1 unchanged.
- R10: Reset fills the array with FFh, clears the lock, the sequencer and the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Byte address |
| din | input | 8 | Write data |
| boot_lock_in | input | 1 | High sets the boot lock |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Output driver enable; 0 stands for high impedance |

## Verification
A sequencer stuck in the wrong step shows up at the ports as a command that never starts or a byte that changes without a full key sequence. Either is visible on the first read after the final write cycle. A wrong busy counter changes how many polled reads return the inverted status bit before real data comes back, so the error appears within one operation window. A lost lock, or an erase that ignores it, appears as FFh at the lowest boot address as soon as the erase completes. A wrong program merge shows as bits read back as 1 that had already been cleared.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_t;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_ERASE
  } op_t;

  // Program can only pull bits toward 0.
  function automatic logic [7:0] merge_prog(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status byte shown on the read path while an operation runs.
  function automatic logic [7:0] poll_byte(input op_t op, input logic d7);
    return (op == OP_PROG) ? {~d7, 7'b0} : 8'h00;
  endfunction

  // True when an array index falls in the protected region.
  function automatic logic in_boot(input int idx, input int boot_bytes);
    return idx < boot_bytes;
  endfunction

endpackage

// File: rtl/flash_bus_edge.sv
module flash_bus_edge #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_fall,
  output logic              wr_rise,
  output logic [ADDR_W-1:0] addr_lat
);
  logic strobe, strobe_q;

  assign strobe  = ce_n | we_n;
  assign wr_fall = strobe_q & ~strobe;
  assign wr_rise = ~strobe_q & strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b1;
      addr_lat <= '0;
    end else begin
      strobe_q <= strobe;
      if (wr_fall) addr_lat <= addr;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] KEY_A1   = 16'h5555,
  parameter logic [15:0] KEY_A2   = 16'h2AAA,
  parameter logic [7:0]  KEY_D1   = 8'hAA,
  parameter logic [7:0]  KEY_D2   = 8'h55,
  parameter logic [7:0]  CMD_PGM  = 8'hA0,
  parameter logic [7:0]  CMD_EXT  = 8'h80,
  parameter logic [7:0]  CMD_CHIP = 8'h10,
  parameter logic [7:0]  CMD_LOCK = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [7:0]        cyc_data,
  output logic              pgm_go,
  output logic              erase_go,
  output logic              lock_go
);
  seq_t state, nxt;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                               input logic [15:0] ka, input logic [7:0] kd);
    return (a == ADDR_W'(ka)) && (d == kd);
  endfunction

  always_comb begin
    nxt      = state;
    pgm_go   = 1'b0;
    erase_go = 1'b0;
    lock_go  = 1'b0;
    if (cyc_valid) begin
      nxt = SQ_IDLE;
      unique case (state)
        SQ_IDLE: if (hit(cyc_addr, cyc_data, KEY_A1, KEY_D1)) nxt = SQ_K1;
        SQ_K1:   if (hit(cyc_addr, cyc_data, KEY_A2, KEY_D2)) nxt = SQ_K2;
        SQ_K2: begin
          if (hit(cyc_addr, cyc_data, KEY_A1, CMD_PGM))      nxt = SQ_PGM;
          else if (hit(cyc_addr, cyc_data, KEY_A1, CMD_EXT)) nxt = SQ_E3;
        end
        SQ_PGM:  pgm_go = 1'b1;
        SQ_E3:   if (hit(cyc_addr, cyc_data, KEY_A1, KEY_D1)) nxt = SQ_E4;
        SQ_E4:   if (hit(cyc_addr, cyc_data, KEY_A2, KEY_D2)) nxt = SQ_E5;
        SQ_E5: begin
          erase_go = hit(cyc_addr, cyc_data, KEY_A1, CMD_CHIP);
          lock_go  = hit(cyc_addr, cyc_data, KEY_A1, CMD_LOCK);
        end
        default: nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_pkg::*;
#(
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_go,
  input  logic erase_go,
  output logic busy,
  output op_t  op,
  output logic done
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign busy = (op != OP_NONE);
  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op  <= OP_NONE;
      cnt <= '0;
    end else if (!busy) begin
      if (pgm_go) begin
        op  <= OP_PROG;
        cnt <= CW'(PROG_CYC - 1);
      end else if (erase_go) begin
        op  <= OP_ERASE;
        cnt <= CW'(ERASE_CYC - 1);
      end
    end else if (done) begin
      op <= OP_NONE;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MEM_AW     = 8,
  parameter int BOOT_BYTES = 32,
  parameter int PROG_CYC   = 40,
  parameter int ERASE_CYC  = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              boot_lock_in,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [7:0]        mem [MEM_DEPTH];
  logic              wr_fall, wr_rise;
  logic [ADDR_W-1:0] addr_lat;
  logic              cyc_valid, pgm_go, erase_go, lock_go;
  logic              busy, done;
  op_t               op;
  logic              lock_q;
  logic [MEM_AW-1:0] pidx;
  logic [7:0]        pdata;
  logic              prog_we;
  logic [7:0]        prog_old, prog_new;
  logic [7:0]        rd_val;

  flash_bus_edge #(.ADDR_W(ADDR_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .wr_fall(wr_fall), .wr_rise(wr_rise), .addr_lat(addr_lat)
  );

  assign cyc_valid = wr_rise & ~busy;

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(addr_lat),
    .cyc_data(din), .pgm_go(pgm_go), .erase_go(erase_go), .lock_go(lock_go)
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .pgm_go(pgm_go), .erase_go(erase_go),
    .busy(busy), .op(op), .done(done)
  );

  assign prog_we  = done && (op == OP_PROG);
  assign prog_old = mem[pidx];
  assign prog_new = merge_prog(prog_old, pdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pidx   <= '0;
      pdata  <= 8'hFF;
      lock_q <= 1'b0;
    end else begin
      if (pgm_go && !busy) begin
        pidx  <= addr_lat[MEM_AW-1:0];
        pdata <= din;
      end
      if (lock_go || boot_lock_in) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_we) begin
      mem[pidx] <= prog_new;
    end else if (done && (op == OP_ERASE)) begin
      for (int i = 0; i < MEM_DEPTH; i++)
        if (!(lock_q && in_boot(i, BOOT_BYTES))) mem[i] <= 8'hFF;
    end
  end

  assign rd_val  = busy ? poll_byte(op, pdata[7]) : mem[addr[MEM_AW-1:0]];
  assign dout_en = ~ce_n & ~oe_n & we_n;
  assign dout    = dout_en ? rd_val : 8'h00;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic       wr_rise,
  input logic       pgm_go,
  input logic       erase_go,
  input logic       lock_go,
  input logic       busy,
  input logic       lock_q,
  input logic       prog_we,
  input logic [7:0] prog_old,
  input logic [7:0] prog_new
);
  assert_read_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n && we_n));

  assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> ((prog_new & ~prog_old) == 8'h00));

  assert_cmd_on_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_go || erase_go || lock_go) |-> wr_rise);

  assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_go, erase_go, lock_go}));

  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(pgm_go || erase_go || lock_go));

  assert_poll_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dout_en) |-> (dout[6:0] == 7'h00));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .dout_en(dout_en), .dout(dout), .wr_rise(wr_rise), .pgm_go(pgm_go),
  .erase_go(erase_go), .lock_go(lock_go), .busy(busy), .lock_q(lock_q),
  .prog_we(prog_we), .prog_old(prog_old), .prog_new(prog_new)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  localparam int PROG_CYC  = 40;
  localparam int ERASE_CYC = 120;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic        boot_lock_in = 1'b0;
  logic [7:0]  dout;
  logic        dout_en;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .boot_lock_in(boot_lock_in),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; boot_lock_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Address valid at strobe fall, then corrupted; data valid only at rise.
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit ce_last);
    @(negedge clk);
    oe_n = 1'b1; addr = a; din = ~d;
    if (ce_last) begin
      we_n = 1'b0; @(negedge clk); ce_n = 1'b0;
    end else begin
      ce_n = 1'b0; @(negedge clk); we_n = 1'b0;
    end
    @(negedge clk);
    addr = a ^ 16'h0F0F; din = d;
    @(negedge clk);
    if (ce_last) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    we_n = 1'b1; addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 v = dout;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d, input bit ce_last);
    bus_write(16'h5555, 8'hAA, ce_last);
    bus_write(16'h2AAA, 8'h55, ce_last);
    bus_write(16'h5555, 8'hA0, ce_last);
    bus_write(a, d, ce_last);
  endtask

  task automatic ext_cmd(input logic [7:0] last);
    bus_write(16'h5555, 8'hAA, 1'b0);
    bus_write(16'h2AAA, 8'h55, 1'b0);
    bus_write(16'h5555, 8'h80, 1'b0);
    bus_write(16'h5555, 8'hAA, 1'b0);
    bus_write(16'h2AAA, 8'h55, 1'b0);
    bus_write(16'h5555, last, 1'b0);
  endtask

  // Counts polled reads until bit 7 matches the final value.
  task automatic wait_ready(input logic [15:0] a, input logic [7:0] exp, output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      we_n = 1'b1; addr = a; ce_n = 1'b0; oe_n = 1'b0;
      #1;
      if (dout[7] == exp[7]) break;
      n++;
    end
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R10 dout_en after reset", int'(dout_en), 0);
    rd(16'h0000, v); check("R10 erased byte 0", v, 8'hFF);
    rd(16'h00FF, v); check("R10 erased byte FF", v, 8'hFF);
  endtask

  task automatic t_hiz();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ce_n = c[2]; oe_n = c[1]; we_n = c[0]; addr = 16'h0010;
      #1;
      if (c == 1) check("R1 driven read", int'(dout_en), 1);
      else begin
        check("R1 high-Z enable", int'(dout_en), 0);
        check("R1 high-Z data", dout, 8'h00);
      end
    end
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic t_program();
    logic [7:0] v;
    int n;
    prog(16'h0040, 8'h3C, 1'b1);
    wait_ready(16'h0040, 8'h3C, n);
    check("R7 R8 program busy polls", n, PROG_CYC - 1);
    rd(16'h0040, v); check("R3 R5 programmed byte", v, 8'h3C);
  endtask

  task automatic t_and();
    logic [7:0] v;
    prog(16'h0040, 8'hF0, 1'b0);
    idle(PROG_CYC + 4);
    rd(16'h0040, v); check("R2 AND merge", v, 8'h30);
    prog(16'h0040, 8'hFF, 1'b0);
    idle(PROG_CYC + 4);
    rd(16'h0040, v); check("R2 no 0 to 1", v, 8'h30);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    int n;
    prog(16'h0041, 8'h5A, 1'b0);
    rd(16'h0041, v); check("R8 poll status", v, 8'h80);
    prog(16'h0042, 8'h00, 1'b0);
    wait_ready(16'h0041, 8'h5A, n);
    rd(16'h0041, v); check("R8 first program done", v, 8'h5A);
    idle(PROG_CYC + 4);
    rd(16'h0042, v); check("R8 write while busy ignored", v, 8'hFF);
  endtask

  task automatic t_broken();
    logic [7:0] v;
    bus_write(16'h5555, 8'hAA, 1'b0);
    bus_write(16'h2AAA, 8'h55, 1'b0);
    bus_write(16'h1234, 8'hA0, 1'b0);
    bus_write(16'h0043, 8'h00, 1'b0);
    rd(16'h0043, v); check("R6 bad third cycle no busy", v, 8'hFF);
    bus_write(16'h5555, 8'hAA, 1'b0);
    bus_write(16'h2AAA, 8'h54, 1'b0);
    bus_write(16'h5555, 8'hA0, 1'b0);
    bus_write(16'h0043, 8'h00, 1'b0);
    idle(PROG_CYC + 4);
    rd(16'h0043, v); check("R6 bad key data no write", v, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    int n;
    prog(16'h0005, 8'h00, 1'b0); idle(PROG_CYC + 4);
    ext_cmd(8'h10);
    wait_ready(16'h0080, 8'hFF, n);
    check("R4 R7 erase busy polls", n, ERASE_CYC - 1);
    rd(16'h0005, v); check("R4 boot byte erased when unlocked", v, 8'hFF);
    rd(16'h0040, v); check("R4 byte 40 erased", v, 8'hFF);
  endtask

  task automatic t_lock_cmd();
    logic [7:0] v;
    prog(16'h0005, 8'h11, 1'b0); idle(PROG_CYC + 4);
    prog(16'h001F, 8'h0F, 1'b0); idle(PROG_CYC + 4);
    prog(16'h0020, 8'h00, 1'b0); idle(PROG_CYC + 4);
    prog(16'h0090, 8'h22, 1'b0); idle(PROG_CYC + 4);
    ext_cmd(8'h40);
    rd(16'h0005, v); check("R9 lock command not busy", v, 8'h11);
    ext_cmd(8'h10); idle(ERASE_CYC + 4);
    rd(16'h0005, v); check("R9 boot byte kept", v, 8'h11);
    rd(16'h001F, v); check("R9 last boot byte kept", v, 8'h0F);
    rd(16'h0020, v); check("R4 first byte past boot erased", v, 8'hFF);
    rd(16'h0090, v); check("R4 upper byte erased", v, 8'hFF);
  endtask

  task automatic t_lock_pin();
    logic [7:0] v;
    do_reset();
    rd(16'h0005, v); check("R10 reset refills array", v, 8'hFF);
    prog(16'h0006, 8'h00, 1'b0); idle(PROG_CYC + 4);
    @(negedge clk); boot_lock_in = 1'b1;
    @(negedge clk); boot_lock_in = 1'b0;
    ext_cmd(8'h10); idle(ERASE_CYC + 4);
    rd(16'h0006, v); check("R9 pin lock kept boot byte", v, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_hiz();
    t_program();
    t_and();
    t_busy_ignore();
    t_broken();
    t_erase();
    t_lock_cmd();
    t_lock_pin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule